// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the target side of a parallel bus with no bus clock. One set of shared lines carries first an address and then data. Three strobes separate the phases: an address-latch strobe, a read strobe and a write strobe. The block runs on its own local clock. It passes each strobe through a two-flop synchroniser and then works from the synchronised edges.

On the leading edge of the address strobe, the block captures the address from the shared lines and keeps it after the master removes it. It compares the upper address bits against a fixed window to form a single select. The low address bits index an internal byte-wide register array. During a selected read, the block drives the stored byte onto the low lane and holds every upper lane of the wider data bus at zero. It releases the lines after the read strobe ends. During a selected write, it stores the low byte of the bus at the trailing edge of the write strobe.

A parameter selects a non-multiplexed variant. In that variant the address arrives on dedicated lines and is taken at the leading edge of a read or write strobe, and the address strobe has no effect. The shared lines are split into an input, an output and an output enable, so that the tri-state buffer sits at the pad.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset, `ad_oe_o` is 0, `ad_o` is all zeros, and every byte of the register array reads back as 0x00.
- R2: In multiplexed mode, the address is taken from `ad_i[ADDR_W-1:0]` at the synchronised rising edge of `ale_i`. It is held unchanged after `ale_i` falls and the shared lines change, until the next rising edge of `ale_i`.
- R3: An access is selected when address bits `[ADDR_W-1:MEM_AW]` equal the same bits of `BASE`. On a selected read, `ad_oe_o` is 1 within 5 clock cycles after `rd_i` rises, and `ad_o[DEV_W-1:0]` equals the byte stored at offset `address[MEM_AW-1:0]`.
- R4: Bits `ad_o[DATA_W-1:DEV_W]` are always 0. The whole of `ad_o` is 0 whenever `ad_oe_o` is 0.
- R5: `ad_oe_o` returns to 0 within 5 clock cycles after `rd_i` falls.
- R6: On a selected write, the byte at the addressed offset takes the value of `ad_i[DEV_W-1:0]` at the synchronised falling edge of `wr_i`. The bus data must be held for at least 3 clock cycles after `wr_i` falls.
- R7: An access outside the window never drives the lines and never changes the register array.
- R8: `ad_oe_o` is 0 in every cycle that follows a cycle in which the synchronised write strobe is high. In multiplexed mode this also applies to the synchronised address strobe. A read whose strobe rises while the address strobe is high is abandoned, and nothing is driven for the rest of that read pulse.
- R9: With `MUX_MODE = 0`, the address is taken from `addr_i` at the leading edge of a read or write strobe, and `ale_i` has no effect.
- R10: Bits `ad_i[DATA_W-1:DEV_W]` during a write have no effect on the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock, at least 4x faster than the shortest strobe pulse |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address-valid strobe, active high, asynchronous |
| rd_i | input | 1 | Read strobe, active high, asynchronous |
| wr_i | input | 1 | Write strobe, active high, asynchronous |
| addr_i | input | ADDR_W | Dedicated address lines, used only when MUX_MODE = 0 |
| ad_i | input | DATA_W | Shared address/data lines as seen from the pad |
| ad_o | output | DATA_W | Data driven toward the pad during a selected read |
| ad_oe_o | output | 1 | Output enable for the shared lines |

## Verification
The bench builds two copies of the block side by side: one with the default multiplexed setting and one with `MUX_MODE = 0`. Both use a 32-bit bus, an 8-bit device, a 16-bit address and a 16-byte window at 0x4A30. Sharing the strobes between the two copies exposes the two address paths to the same traffic. A directed case gives the shared lines and the dedicated address lines different addresses, so each copy has to pick its own source. A read raised under a high address strobe must be dropped by the multiplexed copy and served by the other. The small window lets random addresses land on every offset and repeatedly overwrite it. Writes carry random upper bits, which exercises the zero fill and the byte masking.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int NUM_STB = 3;
  localparam int STB_ALE = 0;
  localparam int STB_RD  = 1;
  localparam int STB_WR  = 2;
endpackage

// File: rtl/mbs_strobe_sync.sv
module mbs_strobe_sync #(
  parameter int NUM = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] async_i,
  output logic [NUM-1:0] lvl_o,
  output logic [NUM-1:0] rise_o,
  output logic [NUM-1:0] fall_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_stb
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= async_i[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[i]  = s2_q;
    assign rise_o[i] = s2_q & ~s3_q;
    assign fall_o[i] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/mbs_addr_dec.sv
module mbs_addr_dec #(
  parameter int                 ADDR_W   = 16,
  parameter int                 MEM_AW   = 4,
  parameter logic [ADDR_W-1:0]  BASE     = 16'h4A30,
  parameter bit                 MUX_MODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_rise_i,
  input  logic              acc_rise_i,
  input  logic [ADDR_W-1:0] ad_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_o,
  output logic [MEM_AW-1:0] off_o
);
  localparam int WIN_W = ADDR_W - MEM_AW;
  localparam logic [WIN_W-1:0] WIN = BASE[ADDR_W-1:MEM_AW];

  logic              cap;
  logic [ADDR_W-1:0] src;
  logic [ADDR_W-1:0] addr_q;

  if (MUX_MODE) begin : g_mux
    assign cap = ale_rise_i;
    assign src = ad_i;
  end else begin : g_sep
    assign cap = acc_rise_i;
    assign src = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  addr_q <= '0;
    else if (cap) addr_q <= src;
  end

  assign sel_o = (addr_q[ADDR_W-1:MEM_AW] == WIN);
  assign off_o = addr_q[MEM_AW-1:0];

  // latched address survives removal from the shared lines
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(addr_q));
endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
  parameter int DEV_W  = 8,
  parameter int MEM_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] off_i,
  input  logic [DEV_W-1:0]  wdata_i,
  output logic [DEV_W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DEPTH-1:0][DEV_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[off_i] <= wdata_i;
  end

  assign rdata_o = mem_q[off_i];

  p_mem_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int                DATA_W   = 32,
  parameter int                DEV_W    = 8,
  parameter int                ADDR_W   = 16,
  parameter int                MEM_AW   = 4,
  parameter logic [ADDR_W-1:0] BASE     = 16'h4A30,
  parameter bit                MUX_MODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o
);
  import mbs_pkg::*;

  logic [NUM_STB-1:0] stb_raw, stb_lvl, stb_rise, stb_fall;
  logic               ale_eff, sel, we, rd_rise_q, rd_active_q;
  logic [MEM_AW-1:0]  off;
  logic [DEV_W-1:0]   rdata;

  assign stb_raw[STB_ALE] = ale_i;
  assign stb_raw[STB_RD]  = rd_i;
  assign stb_raw[STB_WR]  = wr_i;

  mbs_strobe_sync #(.NUM(NUM_STB)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (stb_raw),
    .lvl_o   (stb_lvl),
    .rise_o  (stb_rise),
    .fall_o  (stb_fall)
  );

  // no ALE in the separate-address variant
  assign ale_eff = MUX_MODE ? stb_lvl[STB_ALE] : 1'b0;

  mbs_addr_dec #(
    .ADDR_W   (ADDR_W),
    .MEM_AW   (MEM_AW),
    .BASE     (BASE),
    .MUX_MODE (MUX_MODE)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ale_rise_i (stb_rise[STB_ALE]),
    .acc_rise_i (stb_rise[STB_RD] | stb_rise[STB_WR]),
    .ad_i       (ad_i[ADDR_W-1:0]),
    .addr_i     (addr_i),
    .sel_o      (sel),
    .off_o      (off)
  );

  assign we = stb_fall[STB_WR] & sel;

  mbs_regfile #(.DEV_W(DEV_W), .MEM_AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .off_i   (off),
    .wdata_i (ad_i[DEV_W-1:0]),
    .rdata_o (rdata)
  );

  // one cycle delay so a separate-bus address is latched before decode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_rise_q   <= 1'b0;
      rd_active_q <= 1'b0;
    end else begin
      rd_rise_q <= stb_rise[STB_RD];
      if (stb_fall[STB_RD] | ale_eff | stb_lvl[STB_WR])
        rd_active_q <= 1'b0;
      else if (rd_rise_q & sel & stb_lvl[STB_RD])
        rd_active_q <= 1'b1;
    end
  end

  assign ad_oe_o = rd_active_q;
  assign ad_o    = rd_active_q ? DATA_W'(rdata) : '0;

  p_no_fight_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_eff || stb_lvl[STB_WR]) |=> !ad_oe_o);
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_fall[STB_RD] |=> !ad_oe_o);
  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ad_oe_o |-> (ad_o == '0));
  p_drive_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ad_oe_o) |-> sel);
endmodule

// File: tb/mux_bus_slave_bench.sv
module mux_bus_slave_bench;
  localparam logic [15:0] BASE = 16'h4A30;

  logic        clk = 0, rst_n = 0;
  logic        ale = 0, rd = 0, wr = 0;
  logic [15:0] addr = '0;
  logic [31:0] ad = '0;
  logic [31:0] ad_o_m, ad_o_n;
  logic        oe_m, oe_n;
  logic [7:0]  model_m [16];
  logic [7:0]  model_n [16];
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  mux_bus_slave #(.BASE(BASE), .MUX_MODE(1'b1)) u_mux_bus_slave (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .ad_i(ad), .ad_o(ad_o_m), .ad_oe_o(oe_m));

  mux_bus_slave #(.BASE(BASE), .MUX_MODE(1'b0)) u_mux_bus_slave_sep (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .ad_i(ad), .ad_o(ad_o_n), .ad_oe_o(oe_n));

  function automatic bit in_win(logic [15:0] a);
    return a[15:4] == BASE[15:4];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // a_bus on shared lines, a_sep on dedicated lines
  task automatic addr_phase(logic [15:0] a_bus, logic [15:0] a_sep);
    @(negedge clk);
    ad = {$urandom} & 32'hFFFF_0000 | 32'(a_bus);
    addr = a_sep;
    ale = 1;
    wait_n(5);
    ale = 0;
    wait_n(1);
    ad = $urandom;  // R2: address removed from the lines
  endtask

  task automatic do_write(logic [15:0] a, logic [31:0] d);
    addr_phase(a, a);
    ad = d;
    wr = 1;
    wait_n(5);
    wr = 0;
    wait_n(4);
    ad = $urandom;
    if (in_win(a)) begin
      model_m[a[3:0]] = d[7:0];
      model_n[a[3:0]] = d[7:0];
    end
    wait_n(2);
  endtask

  task automatic read_chk(logic [15:0] am, logic [15:0] an, string tag);
    logic [31:0] em, en;
    addr_phase(am, an);
    em = in_win(am) ? {24'h0, model_m[am[3:0]]} : 32'h0;
    en = in_win(an) ? {24'h0, model_n[an[3:0]]} : 32'h0;
    rd = 1;
    wait_n(5);
    chk(oe_m == in_win(am), {tag, " R3/R7 oe mux"}, 32'(oe_m), 32'(in_win(am)));
    chk(ad_o_m == em, {tag, " R3/R4 data mux"}, ad_o_m, em);
    chk(oe_n == in_win(an), {tag, " R9 oe sep"}, 32'(oe_n), 32'(in_win(an)));
    chk(ad_o_n == en, {tag, " R9/R4 data sep"}, ad_o_n, en);
    rd = 0;
    wait_n(5);
    chk(!oe_m && !oe_n, {tag, " R5 release"}, {oe_m, oe_n}, 32'h0);
    chk(ad_o_m == 0 && ad_o_n == 0, {tag, " R4 idle zero"}, ad_o_m | ad_o_n, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin
      model_m[i] = 8'h00;
      model_n[i] = 8'h00;
    end
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    // R1 reset state
    chk(!oe_m && !oe_n, "R1 oe after reset", {oe_m, oe_n}, 32'h0);
    chk(ad_o_m == 0 && ad_o_n == 0, "R1 ad_o after reset", ad_o_m | ad_o_n, 32'h0);
    read_chk(16'h4A30, 16'h4A30, "R1 offset0");
    read_chk(16'h4A3F, 16'h4A3F, "R1 offset15");
    // R6, R10: write with junk upper bits
    do_write(16'h4A35, 32'hDEAD_BE5A);
    read_chk(16'h4A35, 16'h4A35, "R6/R10 write");
    // R7: outside window, same offset bits
    do_write(16'h1235, 32'h0000_00C3);
    read_chk(16'h4A35, 16'h4A35, "R7 no write");
    read_chk(16'h1235, 16'h1235, "R7 no drive");
    // R9, R2: separate address differs from shared-line address
    do_write(16'h4A31, 32'h11);
    do_write(16'h4A32, 32'h22);
    read_chk(16'h4A31, 16'h4A32, "R9/R2 addr source");
    // R8: read raised under ALE; mux abandons, separate copy serves
    @(negedge clk);
    ad = 32'h4A31; addr = 16'h4A32; ale = 1;
    wait_n(5);
    rd = 1;
    wait_n(5);
    chk(!oe_m, "R8 no drive under ALE", 32'(oe_m), 32'h0);
    chk(oe_n && ad_o_n == 32'h22, "R9 ALE ignored", ad_o_n, 32'h22);
    ale = 0;
    wait_n(5);
    chk(!oe_m, "R8 abandoned read", 32'(oe_m), 32'h0);
    rd = 0;
    wait_n(5);
    // R8: WR overlapping an active read
    addr_phase(16'h4A37, 16'h4A37);
    rd = 1;
    wait_n(5);
    chk(oe_m && oe_n, "R8 read active before WR", {oe_m, oe_n}, 32'h3);
    ad = 32'h0000_0077;
    wr = 1;
    wait_n(5);
    chk(!oe_m && !oe_n, "R8 no drive under WR", {oe_m, oe_n}, 32'h0);
    wr = 0;
    wait_n(4);
    rd = 0;
    model_m[7] = 8'h77;
    model_n[7] = 8'h77;
    wait_n(5);
    read_chk(16'h4A37, 16'h4A37, "R6 overlap write");
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [15:0] a;
      a = ($urandom % 4 != 0) ? {BASE[15:4], 4'($urandom)} : 16'($urandom);
      if ($urandom % 2) do_write(a, $urandom);
      else read_chk(a, a, "rand");
    end
    for (int i = 0; i < 16; i++) read_chk({BASE[15:4], 4'(i)}, {BASE[15:4], 4'(i)}, "final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule